// File: doc/BRIEF.md
# Dual-Clock FIFO with Gray-Coded Pointer Flags

This block moves data words from a write clock domain to an unrelated read clock domain. Storage is a register array with one write port and one read port. Each side keeps its own binary address counter and a Gray-coded copy of it. Both copies are loaded on the same clock edge, so the Gray copy is ready in the same cycle as the binary count.

Only the Gray copy crosses to the other domain. It comes straight from a flop and passes through a two-flop synchronizer in the receiving domain. The empty and full flags come from an equality test on Gray pointers. Each flag turns on as soon as its own side's pointer moves. Each flag turns off only when the other side's pointer has come through the synchronizer.

The read side turns the synchronized write pointer back into binary. From that it produces a fill level and an almost-empty flag. The read port is registered: a word appears on the read clock edge that accepts the read.

Top module: `dual_clock_fifo`

## Requirements
- R1: While the resets are held and right after they are released, `empty_o` is 1, `full_o` is 0, `rd_level_o` is 0 and `almost_empty_o` is 1.
- R2: Words come out in the order they were accepted, with no loss and no duplication. The read clock edge that accepts a read also loads that word onto `rd_data_o`. This holds under unrelated clocks with a write:read frequency ratio of 2:5.
- R3: A write attempted while `full_o` is 1 is ignored. It neither stores a word nor moves the write pointer, and the word never appears at the output.
- R4: A read attempted while `empty_o` is 1 is ignored. `rd_data_o` holds its value and the read pointer does not move.
- R5: `empty_o` becomes 1 just after the read clock edge that takes the last stored word, with no extra cycle.
- R6: After a write into an empty FIFO, `empty_o` is still 1 after the first read clock edge that follows the write edge. It is 0 by the third such edge.
- R7: `full_o` becomes 1 just after the write clock edge that stores the DEPTH-th word, with no extra cycle.
- R8: After a read from a full FIFO, `full_o` is still 1 after the first write clock edge that follows the read edge. It is 0 by the third such edge.
- R9: `rd_level_o` is the synchronized write count minus the read count, a value from 0 to DEPTH. Once both sides have been idle long enough for the pointers to cross, it equals the true occupancy.
- R10: `almost_empty_o` is 1 exactly when `rd_level_o` is at or below ALMOST_EMPTY_LVL (default 2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write clock |
| wrst_ni | input | 1 | Write-domain active-low asynchronous reset |
| wr_en_i | input | 1 | Write request |
| wr_data_i | input | DATA_W | Word to write |
| full_o | output | 1 | FIFO full, in the write domain |
| rclk_i | input | 1 | Read clock |
| rrst_ni | input | 1 | Read-domain active-low asynchronous reset |
| rd_en_i | input | 1 | Read request |
| rd_data_o | output | DATA_W | Registered read word |
| empty_o | output | 1 | FIFO empty, in the read domain |
| almost_empty_o | output | 1 | Fill level at or below ALMOST_EMPTY_LVL |
| rd_level_o | output | $clog2(DEPTH)+1 | Fill level as seen by the read domain |

## Verification
The following results are due right after the clock edge that causes them, in their own domain:
- read data;
- the onset of `empty_o` on a read;
- the onset of `full_o` on a write.

The bench samples each of these 0.2 ns after that edge.

Flag release must cross the synchronizer, so it is checked in two steps. The flag must still be set one opposite-domain edge after the cause. It must be clear three edges after the cause.

The two clocks are offset by half a nanosecond so that their edges never coincide, which makes every count exact.

Level, almost-empty and the two flags are compared with the queue model only after a settle interval in which the pointers have crossed.

// File: rtl/dcf_pkg.sv
`timescale 1ns/100ps
package dcf_pkg;
  localparam int SYNC_STAGES = 2;

  function automatic logic [31:0] bin_to_gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [31:0] gray_to_bin(input logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction
endpackage

// File: rtl/dcf_sync.sv
`timescale 1ns/100ps
module dcf_sync #(
  parameter int W      = 4,
  parameter int STAGES = dcf_pkg::SYNC_STAGES
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= d_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/dcf_wr_ctrl.sv
`timescale 1ns/100ps
module dcf_wr_ctrl #(
  parameter int AW = 3
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [AW:0] rgray_sync_i,
  output logic        wr_ok_o,
  output logic [AW-1:0] waddr_o,
  output logic [AW:0] wgray_o,
  output logic        full_o
);
  localparam int PW = AW + 1;

  logic [AW:0] bin_q, bin_d, gray_q, gray_d;

  assign wr_ok_o = wr_en_i & ~full_o;
  assign bin_d   = bin_q + PW'(wr_ok_o);
  assign gray_d  = PW'(dcf_pkg::bin_to_gray(32'(bin_d)));

  // binary and Gray copies load on the same edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bin_q  <= '0;
      gray_q <= '0;
    end else begin
      bin_q  <= bin_d;
      gray_q <= gray_d;
    end
  end

  // full: top two Gray bits inverted, rest equal
  assign full_o  = (gray_q == {~rgray_sync_i[AW:AW-1], rgray_sync_i[AW-2:0]});
  assign waddr_o = bin_q[AW-1:0];
  assign wgray_o = gray_q;

  // R3
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && wr_en_i) |=> $stable(bin_q));
  // R2
  wgray_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(gray_q ^ $past(gray_q)) <= 1);
endmodule

// File: rtl/dcf_rd_ctrl.sv
`timescale 1ns/100ps
module dcf_rd_ctrl #(
  parameter int AW       = 3,
  parameter int AE_LEVEL = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        rd_en_i,
  input  logic [AW:0] wgray_sync_i,
  output logic        rd_ok_o,
  output logic [AW-1:0] raddr_o,
  output logic [AW:0] rgray_o,
  output logic        empty_o,
  output logic [AW:0] level_o,
  output logic        almost_empty_o
);
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;

  logic [AW:0] bin_q, bin_d, gray_q, gray_d, wbin_sync;

  assign rd_ok_o = rd_en_i & ~empty_o;
  assign bin_d   = bin_q + PW'(rd_ok_o);
  assign gray_d  = PW'(dcf_pkg::bin_to_gray(32'(bin_d)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bin_q  <= '0;
      gray_q <= '0;
    end else begin
      bin_q  <= bin_d;
      gray_q <= gray_d;
    end
  end

  assign empty_o   = (gray_q == wgray_sync_i);
  assign wbin_sync = PW'(dcf_pkg::gray_to_bin(32'(wgray_sync_i)));
  assign level_o   = wbin_sync - bin_q;
  assign almost_empty_o = (level_o <= PW'(AE_LEVEL));
  assign raddr_o   = bin_q[AW-1:0];
  assign rgray_o   = gray_q;

  // R4
  no_underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && rd_en_i) |=> $stable(bin_q));
  // R2
  rgray_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(gray_q ^ $past(gray_q)) <= 1);
  // R9
  level_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_o <= PW'(DEPTH));
endmodule

// File: rtl/dcf_mem.sv
`timescale 1ns/100ps
module dcf_mem #(
  parameter int DW    = 16,
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          wclk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          rclk_i,
  input  logic          rrst_ni,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge wclk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  always_ff @(posedge rclk_i or negedge rrst_ni) begin
    if (!rrst_ni) rdata_o <= '0;
    else if (re_i) rdata_o <= mem_q[raddr_i];
  end
endmodule

// File: rtl/dual_clock_fifo.sv
`timescale 1ns/100ps
module dual_clock_fifo #(
  parameter int DATA_W           = 16,
  parameter int DEPTH            = 8,
  parameter int ALMOST_EMPTY_LVL = 2,
  localparam int AW              = $clog2(DEPTH)
) (
  input  logic              wclk_i,
  input  logic              wrst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              full_o,
  input  logic              rclk_i,
  input  logic              rrst_ni,
  input  logic              rd_en_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              empty_o,
  output logic              almost_empty_o,
  output logic [AW:0]       rd_level_o
);
  logic          wr_ok, rd_ok;
  logic [AW-1:0] waddr, raddr;
  logic [AW:0]   wgray, rgray, wgray_rs, rgray_ws;

  dcf_wr_ctrl #(.AW(AW)) u_wr (
    .clk_i(wclk_i), .rst_ni(wrst_ni), .wr_en_i(wr_en_i),
    .rgray_sync_i(rgray_ws), .wr_ok_o(wr_ok), .waddr_o(waddr),
    .wgray_o(wgray), .full_o(full_o)
  );

  dcf_rd_ctrl #(.AW(AW), .AE_LEVEL(ALMOST_EMPTY_LVL)) u_rd (
    .clk_i(rclk_i), .rst_ni(rrst_ni), .rd_en_i(rd_en_i),
    .wgray_sync_i(wgray_rs), .rd_ok_o(rd_ok), .raddr_o(raddr),
    .rgray_o(rgray), .empty_o(empty_o), .level_o(rd_level_o),
    .almost_empty_o(almost_empty_o)
  );

  // write pointer into read domain
  dcf_sync #(.W(AW+1)) u_sync_w2r (
    .clk_i(rclk_i), .rst_ni(rrst_ni), .d_i(wgray), .q_o(wgray_rs)
  );

  // read pointer into write domain
  dcf_sync #(.W(AW+1)) u_sync_r2w (
    .clk_i(wclk_i), .rst_ni(wrst_ni), .d_i(rgray), .q_o(rgray_ws)
  );

  dcf_mem #(.DW(DATA_W), .DEPTH(DEPTH)) u_mem (
    .wclk_i(wclk_i), .we_i(wr_ok), .waddr_i(waddr), .wdata_i(wr_data_i),
    .rclk_i(rclk_i), .rrst_ni(rrst_ni), .re_i(rd_ok), .raddr_i(raddr),
    .rdata_o(rd_data_o)
  );

  // R4
  rd_hold_chk: assert property (@(posedge rclk_i) disable iff (!rrst_ni)
    (empty_o && rd_en_i) |=> $stable(rd_data_o));
  // R10
  almost_empty_chk: assert property (@(posedge rclk_i) disable iff (!rrst_ni)
    empty_o |-> almost_empty_o);
endmodule

// File: tb/tb_dual_clock_fifo.sv
`timescale 1ns/100ps
module tb_dual_clock_fifo;
  localparam int DW = 16, DEPTH = 8, AE = 2, AW = 3;

  logic wclk, rclk, wrst_n, rrst_n, wr_en, rd_en;
  logic [DW-1:0] wr_data, rd_data;
  logic full, empty, almost_empty;
  logic [AW:0] level;

  int checks = 0, fails = 0;
  logic [DW-1:0] q[$];
  logic [DW-1:0] seq = 16'h1000;

  // {writes, reads} per step
  localparam logic [15:0] VEC [8] = '{16'h0303, 16'h0100, 16'h0800, 16'h0200,
                                      16'h0009, 16'h0002, 16'h0502, 16'h0407};

  dual_clock_fifo #(.DATA_W(DW), .DEPTH(DEPTH), .ALMOST_EMPTY_LVL(AE)) dut (
    .wclk_i(wclk), .wrst_ni(wrst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .full_o(full), .rclk_i(rclk), .rrst_ni(rrst_n), .rd_en_i(rd_en),
    .rd_data_o(rd_data), .empty_o(empty), .almost_empty_o(almost_empty),
    .rd_level_o(level)
  );

  // write 100 MHz, read 250 MHz (2:5); offset keeps edges apart
  initial begin wclk = 0; forever #5 wclk = ~wclk; end
  initial begin rclk = 0; #0.5; forever #2 rclk = ~rclk; end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_write();
    @(negedge wclk);
    chk(full == (q.size() == DEPTH), "R7 full before write", int'(full), int'(q.size() == DEPTH));
    wr_en = 1; wr_data = seq;
    @(posedge wclk); #0.2;
    if (q.size() < DEPTH) q.push_back(seq);
    seq++;
    wr_en = 0;
    chk(full == (q.size() == DEPTH), "R7 full onset", int'(full), int'(q.size() == DEPTH));
  endtask

  task automatic do_read();
    logic [DW-1:0] old, exp;
    @(negedge rclk);
    chk(empty == (q.size() == 0), "R5 empty before read", int'(empty), int'(q.size() == 0));
    old = rd_data; rd_en = 1;
    @(posedge rclk); #0.2;
    rd_en = 0;
    if (q.size() > 0) begin
      exp = q.pop_front();
      chk(rd_data == exp, "R2 read data", int'(rd_data), int'(exp));
      chk(empty == (q.size() == 0), "R5 empty onset", int'(empty), int'(q.size() == 0));
    end else begin
      chk(rd_data == old, "R4 ignored read holds data", int'(rd_data), int'(old));
    end
  endtask

  task automatic settle();
    repeat (8) @(posedge rclk);
    repeat (4) @(posedge wclk);
    #0.2;
  endtask

  task automatic state_chk();
    chk(int'(level) == q.size(), "R9 level", int'(level), q.size());
    chk(almost_empty == (q.size() <= AE), "R10 almost empty", int'(almost_empty), int'(q.size() <= AE));
    chk(empty == (q.size() == 0), "R5 empty settled", int'(empty), int'(q.size() == 0));
    chk(full == (q.size() == DEPTH), "R7 full settled", int'(full), int'(q.size() == DEPTH));
  endtask

  initial begin
    #600000;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    wrst_n = 0; rrst_n = 0; wr_en = 0; rd_en = 0; wr_data = '0;
    repeat (3) @(posedge wclk);
    #1;
    chk(empty == 1, "R1 empty in reset", int'(empty), 1);
    chk(full == 0, "R1 full in reset", int'(full), 0);
    wrst_n = 1; rrst_n = 1;
    repeat (2) @(posedge wclk); #0.2;
    chk(empty == 1 && almost_empty == 1, "R1 empty after reset", int'(empty), 1);
    chk(full == 0 && level == 0, "R1 full/level after reset", int'(level), 0);

    // vector walk: R2 R3 R4 R5 R7 R9 R10
    foreach (VEC[i]) begin
      for (int w = 0; w < int'(VEC[i][15:8]); w++) do_write();
      settle();
      state_chk();
      for (int r = 0; r < int'(VEC[i][7:0]); r++) do_read();
      settle();
      state_chk();
    end

    // R6: empty release delayed through the synchronizer
    do_write();
    @(posedge rclk); #0.2;
    chk(empty == 1, "R6 empty held one read edge", int'(empty), 1);
    repeat (2) @(posedge rclk); #0.2;
    chk(empty == 0, "R6 empty released by third edge", int'(empty), 0);
    do_read();
    settle();

    // R8: full release delayed through the synchronizer
    for (int w = 0; w < DEPTH; w++) do_write();
    settle();
    do_read();
    @(posedge wclk); #0.2;
    chk(full == 1, "R8 full held one write edge", int'(full), 1);
    repeat (2) @(posedge wclk); #0.2;
    chk(full == 0, "R8 full released by third edge", int'(full), 0);
    while (q.size() > 0) do_read();
    settle();
    state_chk();

    // R2: concurrent streaming, unrelated clocks
    fork
      begin
        int n = 0;
        while (n < 150) begin
          @(negedge wclk);
          wr_en = !full; wr_data = seq;
          @(posedge wclk);
          if (wr_en) begin q.push_back(seq); seq++; n++; end
        end
        #0.2 wr_en = 0;
      end
      begin
        int m = 0;
        logic [DW-1:0] exp;
        while (m < 150) begin
          @(negedge rclk);
          rd_en = !empty;
          @(posedge rclk); #0.2;
          if (rd_en) begin
            exp = q.pop_front();
            chk(rd_data == exp, "R2 streaming order", int'(rd_data), int'(exp));
            m++;
          end
        end
        rd_en = 0;
      end
    join
    settle();
    state_chk();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule